// File: doc/BRIEF.md
# HARQ Bit Collection Interleaver

This block merges the three rate-matched streams of a turbo-coded transport block into one serial stream ready for the physical channel. The three streams are systematic, parity 1 and parity 2. Conceptually the bits are placed in a rectangular matrix whose row count follows the modulation: 2 rows for QPSK, 4 for 16QAM and 6 for 64QAM. The column count is the total bit count divided by the row count. Systematic bits take the top rows. Some columns may hold one more systematic bit than the others. Parity bits fill the rows below, alternating between the two parity streams, with parity 2 first. The matrix is read column by column, top row first.

The readout is column-major and each column is filled from the top down, so the write order and the read order are the same. The block therefore holds no matrix at all. A position walker decides, for the cell it is on, which stream owns that cell. It pulls one bit from that stream and emits it.

A run starts with a start pulse that captures the configuration: mode, total bits, transmitted systematic bits, and the two parity counts. A shared serial divider then derives the column count, the base systematic depth and the number of deeper columns. After that, the walker streams one bit per cycle whenever the stream it needs has a bit valid.

Top module: `harq_bitcol`

## Requirements
- R1: After reset, `out_vld_o`, `busy_o`, `done_o`, `err_o` and all three ready outputs are low.
- R2: The mode code selects the row count: 2'b00 gives 2 rows, 2'b01 gives 4 rows and 2'b10 gives 6 rows. A valid run emits exactly `ndata_i` bits, in column-major order with row 0 first in each column.
- R3: With q = floor(ntsys/ncol) and m = ntsys mod ncol, columns 0..m-1 carry systematic bits in rows 0..q and the other columns in rows 0..q-1. Systematic bits are taken in stream order.
- R4: Every cell that does not hold a systematic bit takes a parity bit. The parity source alternates across the whole run, independent of column boundaries, and the first parity cell takes parity 2.
- R5: At most one ready output is high in a cycle. A bit is consumed on an edge where its ready and valid are both high. `out_vld_o` is high in the following cycle, and `out_bit_o` carries that bit.
- R6: While the stream that owns the current cell has no valid bit, nothing is consumed, `out_vld_o` stays low and the walker position is held.
- R7: A start is rejected when any of these hold: mode code 2'b11; `ntsys_i` greater than `ndata_i`; `np1_i`+`np2_i` not equal to `ndata_i`-`ntsys_i`; `ndata_i` not a multiple of the row count; or `ndata_i` smaller than the row count. A rejected start emits no bits and raises `done_o` with `err_o` high.
- R8: If parity is due from a stream whose count is used up, the bit is taken from the other parity stream and `err_o` rises. The alternation still advances and the run still emits `ndata_i` bits.
- R9: `done_o` is a one-cycle pulse that coincides with the last `out_vld_o` of a run. `busy_o` falls in the next cycle. `err_o` is valid in the `done_o` cycle and holds until the next accepted start.
- R10: A start pulse while `busy_o` is high is ignored, and configuration inputs are used only as captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run with the present configuration |
| mode_i | input | 2 | Modulation code (00 QPSK, 01 16QAM, 10 64QAM) |
| ndata_i | input | CW | Total bits in the run |
| ntsys_i | input | CW | Systematic bits to place |
| np1_i | input | CW | Parity 1 bits available |
| np2_i | input | CW | Parity 2 bits available |
| sys_vld_i | input | 1 | Systematic bit valid |
| sys_bit_i | input | 1 | Systematic bit |
| sys_rdy_o | output | 1 | Walker wants a systematic bit |
| p1_vld_i | input | 1 | Parity 1 bit valid |
| p1_bit_i | input | 1 | Parity 1 bit |
| p1_rdy_o | output | 1 | Walker wants a parity 1 bit |
| p2_vld_i | input | 1 | Parity 2 bit valid |
| p2_bit_i | input | 1 | Parity 2 bit |
| p2_rdy_o | output | 1 | Walker wants a parity 2 bit |
| out_vld_o | output | 1 | Output bit valid |
| out_bit_o | output | 1 | Serial output bit |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished or rejected |
| err_o | output | 1 | Configuration rejected or parity stream exhausted |

## Verification
On every cycle, the assertions check the following:
- at most one stream is requested;
- a consumed bit appears on the output one cycle later, unchanged;
- no output appears without a consumption;
- nothing is requested while idle;
- the done signal lasts a single cycle.

The cell-ownership pattern is only visible across a whole run, so the bench's scenarios must show it. That pattern covers the split systematic depth, parity alternation across column edges, and the row count per mode. The scenarios also show the rejection rules, the parity fallback on exhaustion, stalls from an absent stream, and a start ignored mid-run.

// File: rtl/harq_bitcol_pkg.sv
package harq_bitcol_pkg;

    localparam int ROW_W = 3;

    typedef enum logic [1:0] {
        MOD_QPSK  = 2'd0,
        MOD_16QAM = 2'd1,
        MOD_64QAM = 2'd2,
        MOD_RSVD  = 2'd3
    } mod_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SYS  = 2'd1,
        SRC_PAR1 = 2'd2,
        SRC_PAR2 = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DIVC = 2'd1,
        PH_DIVS = 2'd2,
        PH_RUN  = 2'd3
    } phase_e;

    function automatic logic [ROW_W-1:0] rows_for(input logic [1:0] m);
        logic [ROW_W-1:0] r;
        case (m)
            MOD_QPSK:  r = ROW_W'(2);
            MOD_16QAM: r = ROW_W'(4);
            MOD_64QAM: r = ROW_W'(6);
            default:   r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hbc_divider.sv
module hbc_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         fin_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]     rem;
        logic [W-1:0]     quo;
        logic [CNT_W-1:0] cnt;
        logic             fin;
    } div_t;

    div_t q, d;
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        d       = q;
        d.fin   = 1'b0;
        shifted = {q.rem, q.quo[W-1]};
        trial   = shifted - {1'b0, den_i};
        if (go_i) begin
            d.rem = '0;
            d.quo = num_i;
            d.cnt = CNT_W'(W);
        end else if (q.cnt != '0) begin
            if (!trial[W]) begin
                d.rem = trial[W-1:0];
                d.quo = {q.quo[W-2:0], 1'b1};
            end else begin
                d.rem = shifted[W-1:0];
                d.quo = {q.quo[W-2:0], 1'b0};
            end
            d.cnt = q.cnt - CNT_W'(1);
            d.fin = (q.cnt == CNT_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fin_o = q.fin;
    assign quo_o = q.quo;
    assign rem_o = q.rem;
endmodule

// File: rtl/hbc_walker.sv
module hbc_walker
    import harq_bitcol_pkg::*;
#(
    parameter int CW = 16,
    parameter int RW = ROW_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [RW-1:0] nrow_i,
    input  logic [CW-1:0] ncol_i,
    input  logic [CW-1:0] nr_i,
    input  logic [CW-1:0] nc_i,
    input  logic [CW-1:0] np1_i,
    input  logic [CW-1:0] np2_i,
    input  logic          sys_vld_i,
    input  logic          sys_bit_i,
    input  logic          p1_vld_i,
    input  logic          p1_bit_i,
    input  logic          p2_vld_i,
    input  logic          p2_bit_i,
    output logic          sys_rdy_o,
    output logic          p1_rdy_o,
    output logic          p2_rdy_o,
    output logic          emit_o,
    output logic          bit_o,
    output logic          last_o,
    output logic          runout_o
);
    typedef struct packed {
        logic          active;
        logic [CW-1:0] col;
        logic [RW-1:0] row;
        logic          turn;
        logic [CW-1:0] left1;
        logic [CW-1:0] left2;
        logic          emit;
        logic          bitv;
        logic          last;
        logic          runout;
    } walk_t;

    walk_t q, d;
    src_e  src;
    logic  fallback;
    logic  sys_here;
    logic  take;
    logic  take_bit;
    logic  last_row;
    logic  last_col;
    logic [CW:0] sys_lim;

    // which stream owns the cell under the walker
    always_comb begin
        sys_lim  = {1'b0, nr_i} + ((q.col < nc_i) ? (CW+1)'(1) : '0);
        sys_here = ((CW+1)'(q.row) < sys_lim);
        fallback = 1'b0;
        if (!q.active) begin
            src = SRC_NONE;
        end else if (sys_here) begin
            src = SRC_SYS;
        end else if (q.turn) begin
            if (q.left1 != '0) begin
                src = SRC_PAR1;
            end else begin
                src      = SRC_PAR2;
                fallback = 1'b1;
            end
        end else begin
            if (q.left2 != '0) begin
                src = SRC_PAR2;
            end else begin
                src      = SRC_PAR1;
                fallback = 1'b1;
            end
        end
    end

    assign sys_rdy_o = (src == SRC_SYS);
    assign p1_rdy_o  = (src == SRC_PAR1);
    assign p2_rdy_o  = (src == SRC_PAR2);

    always_comb begin
        take     = (sys_rdy_o && sys_vld_i) || (p1_rdy_o && p1_vld_i) || (p2_rdy_o && p2_vld_i);
        take_bit = sys_rdy_o ? sys_bit_i : (p1_rdy_o ? p1_bit_i : p2_bit_i);
        last_row = (q.row == nrow_i - RW'(1));
        last_col = (q.col == ncol_i - CW'(1));

        d        = q;
        d.emit   = take;
        d.bitv   = take ? take_bit : q.bitv;
        d.last   = 1'b0;
        d.runout = 1'b0;

        if (load_i) begin
            d.active = 1'b1;
            d.col    = '0;
            d.row    = '0;
            d.turn   = 1'b0;
            d.left1  = np1_i;
            d.left2  = np2_i;
        end else if (take) begin
            if (src != SRC_SYS) begin
                d.turn   = ~q.turn;
                d.runout = fallback;
                if (src == SRC_PAR1 && q.left1 != '0) d.left1 = q.left1 - CW'(1);
                if (src == SRC_PAR2 && q.left2 != '0) d.left2 = q.left2 - CW'(1);
            end
            if (last_row) begin
                d.row = '0;
                d.col = q.col + CW'(1);
            end else begin
                d.row = q.row + RW'(1);
            end
            if (last_row && last_col) begin
                d.active = 1'b0;
                d.last   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign emit_o   = q.emit;
    assign bit_o    = q.bitv;
    assign last_o   = q.last;
    assign runout_o = q.runout;
endmodule

// File: rtl/harq_bitcol.sv
module harq_bitcol
    import harq_bitcol_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    mode_i,
    input  logic [CW-1:0] ndata_i,
    input  logic [CW-1:0] ntsys_i,
    input  logic [CW-1:0] np1_i,
    input  logic [CW-1:0] np2_i,
    input  logic          sys_vld_i,
    input  logic          sys_bit_i,
    output logic          sys_rdy_o,
    input  logic          p1_vld_i,
    input  logic          p1_bit_i,
    output logic          p1_rdy_o,
    input  logic          p2_vld_i,
    input  logic          p2_bit_i,
    output logic          p2_rdy_o,
    output logic          out_vld_o,
    output logic          out_bit_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o
);
    localparam int RW = ROW_W;

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] ndata;
        logic [CW-1:0] ntsys;
        logic [CW-1:0] np1;
        logic [CW-1:0] np2;
        logic [RW-1:0] nrow;
        logic [CW-1:0] ncol;
        logic [CW-1:0] nr;
        logic [CW-1:0] nc;
        logic          err;
        logic          done;
        logic          div_go;
        logic          walk_go;
    } ctl_t;

    ctl_t q, d;

    logic          div_fin;
    logic [CW-1:0] div_quo;
    logic [CW-1:0] div_rem;
    logic [CW-1:0] div_num;
    logic [CW-1:0] div_den;
    logic          w_emit;
    logic          w_bit;
    logic          w_last;
    logic          w_runout;
    logic [CW:0]   par_sum;
    logic [CW:0]   par_need;
    logic          cfg_bad;

    // one divider serves both quotients; operands follow the phase
    assign div_num = (q.phase == PH_DIVS) ? q.ntsys : q.ndata;
    assign div_den = (q.phase == PH_DIVS) ? q.ncol  : CW'(q.nrow);

    always_comb begin
        par_sum  = {1'b0, np1_i} + {1'b0, np2_i};
        par_need = {1'b0, ndata_i - ntsys_i};
        cfg_bad  = (mode_i == MOD_RSVD) || (ntsys_i > ndata_i) || (par_sum != par_need);

        d         = q;
        d.done    = 1'b0;
        d.div_go  = 1'b0;
        d.walk_go = 1'b0;
        if (w_runout) d.err = 1'b1;

        case (q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    d.ndata = ndata_i;
                    d.ntsys = ntsys_i;
                    d.np1   = np1_i;
                    d.np2   = np2_i;
                    d.nrow  = rows_for(mode_i);
                    d.err   = 1'b0;
                    if (cfg_bad) begin
                        d.err  = 1'b1;
                        d.done = 1'b1;
                    end else begin
                        d.phase  = PH_DIVC;
                        d.div_go = 1'b1;
                    end
                end
            end
            PH_DIVC: begin
                if (div_fin) begin
                    d.ncol = div_quo;
                    if (div_quo == '0 || div_rem != '0) begin
                        d.err   = 1'b1;
                        d.done  = 1'b1;
                        d.phase = PH_IDLE;
                    end else begin
                        d.div_go = 1'b1;
                        d.phase  = PH_DIVS;
                    end
                end
            end
            PH_DIVS: begin
                if (div_fin) begin
                    d.nr      = div_quo;
                    d.nc      = div_rem;
                    d.walk_go = 1'b1;
                    d.phase   = PH_RUN;
                end
            end
            default: begin
                if (w_last) d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    hbc_divider #(.W(CW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go_i  (q.div_go),
        .num_i (div_num),
        .den_i (div_den),
        .fin_o (div_fin),
        .quo_o (div_quo),
        .rem_o (div_rem)
    );

    hbc_walker #(.CW(CW), .RW(RW)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (q.walk_go),
        .nrow_i    (q.nrow),
        .ncol_i    (q.ncol),
        .nr_i      (q.nr),
        .nc_i      (q.nc),
        .np1_i     (q.np1),
        .np2_i     (q.np2),
        .sys_vld_i (sys_vld_i),
        .sys_bit_i (sys_bit_i),
        .p1_vld_i  (p1_vld_i),
        .p1_bit_i  (p1_bit_i),
        .p2_vld_i  (p2_vld_i),
        .p2_bit_i  (p2_bit_i),
        .sys_rdy_o (sys_rdy_o),
        .p1_rdy_o  (p1_rdy_o),
        .p2_rdy_o  (p2_rdy_o),
        .emit_o    (w_emit),
        .bit_o     (w_bit),
        .last_o    (w_last),
        .runout_o  (w_runout)
    );

    assign out_vld_o = w_emit;
    assign out_bit_o = w_bit;
    assign busy_o    = (q.phase != PH_IDLE);
    assign done_o    = q.done || w_last;
    assign err_o     = q.err || w_runout;
endmodule

// File: rtl/harq_bitcol_chk.sv
module harq_bitcol_chk (
    input logic clk,
    input logic rst_n,
    input logic sys_vld_i,
    input logic sys_bit_i,
    input logic sys_rdy_o,
    input logic p1_vld_i,
    input logic p1_bit_i,
    input logic p1_rdy_o,
    input logic p2_vld_i,
    input logic p2_bit_i,
    input logic p2_rdy_o,
    input logic out_vld_o,
    input logic out_bit_o,
    input logic busy_o,
    input logic done_o
);
    logic any_take;
    assign any_take = (sys_rdy_o && sys_vld_i) || (p1_rdy_o && p1_vld_i) || (p2_rdy_o && p2_vld_i);

    p_one_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sys_rdy_o, p1_rdy_o, p2_rdy_o}));

    p_sys_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rdy_o && sys_vld_i) |=> (out_vld_o && out_bit_o == $past(sys_bit_i)));

    p_p1_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_rdy_o && p1_vld_i) |=> (out_vld_o && out_bit_o == $past(p1_bit_i)));

    p_p2_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (p2_rdy_o && p2_vld_i) |=> (out_vld_o && out_bit_o == $past(p2_bit_i)));

    p_no_take_no_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !any_take |=> !out_vld_o);

    p_idle_no_request_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(sys_rdy_o || p1_rdy_o || p2_rdy_o));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

bind harq_bitcol harq_bitcol_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_vld_i (sys_vld_i),
    .sys_bit_i (sys_bit_i),
    .sys_rdy_o (sys_rdy_o),
    .p1_vld_i  (p1_vld_i),
    .p1_bit_i  (p1_bit_i),
    .p1_rdy_o  (p1_rdy_o),
    .p2_vld_i  (p2_vld_i),
    .p2_bit_i  (p2_bit_i),
    .p2_rdy_o  (p2_rdy_o),
    .out_vld_o (out_vld_o),
    .out_bit_o (out_bit_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/sim_harq_bitcol.sv
module sim_harq_bitcol;
    localparam int CW = 16;
    localparam int MAXB = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [1:0] mode_i = '0;
    logic [CW-1:0] ndata_i = '0, ntsys_i = '0, np1_i = '0, np2_i = '0;
    logic sys_vld_i = 1'b0, sys_bit_i = 1'b0, p1_vld_i = 1'b0, p1_bit_i = 1'b0;
    logic p2_vld_i = 1'b0, p2_bit_i = 1'b0;
    logic sys_rdy_o, p1_rdy_o, p2_rdy_o, out_vld_o, out_bit_o, busy_o, done_o, err_o;

    int total = 0;
    int bad = 0;

    bit sys_a [MAXB];
    bit p1_a  [MAXB];
    bit p2_a  [MAXB];
    bit exp_b [MAXB];
    int exp_s [MAXB];
    bit got_b [MAXB];

    always #10 clk = ~clk;

    harq_bitcol #(.CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .ndata_i(ndata_i), .ntsys_i(ntsys_i), .np1_i(np1_i), .np2_i(np2_i),
        .sys_vld_i(sys_vld_i), .sys_bit_i(sys_bit_i), .sys_rdy_o(sys_rdy_o),
        .p1_vld_i(p1_vld_i), .p1_bit_i(p1_bit_i), .p1_rdy_o(p1_rdy_o),
        .p2_vld_i(p2_vld_i), .p2_bit_i(p2_bit_i), .p2_rdy_o(p2_rdy_o),
        .out_vld_o(out_vld_o), .out_bit_o(out_bit_o), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o)
    );

    task automatic check(input string req, input string what, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic bit pat(input int i, input int s);
        int v;
        v = i * 1103515245 + s * 12345 + (i >> 3);
        return v[13];
    endfunction

    task automatic t_reset();
        check("R1", "out_vld after reset", int'(out_vld_o), 0);
        check("R1", "busy after reset", int'(busy_o), 0);
        check("R1", "done/err after reset", int'(done_o | err_o), 0);
        check("R1", "ready after reset", int'(sys_rdy_o | p1_rdy_o | p2_rdy_o), 0);
    endtask

    // drives one run and compares it with a model built from the requirements
    task automatic run_case(input string name, input int mode, input int nd, input int ns,
                            input int n1, input int n2, input bit stall, input bit poke,
                            input bit cfg_err);
        int nrow, ncol, q, m, pos, l1, l2, si, i1, i2, ue1, ue2, n, cyc, stall_bad;
        bit turn, rout, done_seen, err_seen, took_s, took_1, took_2, stalled;
        string tag;
        nrow = (mode == 0) ? 2 : (mode == 1) ? 4 : 6;
        for (int k = 0; k < MAXB; k++) begin
            sys_a[k] = pat(k, 1); p1_a[k] = pat(k, 2); p2_a[k] = pat(k, 3);
        end
        rout = 1'b0; ue1 = 0; ue2 = 0;
        if (!cfg_err) begin
            ncol = nd / nrow; q = ns / ncol; m = ns % ncol;
            pos = 0; l1 = n1; l2 = n2; si = 0; turn = 1'b0;
            for (int c = 0; c < ncol; c++) begin
                for (int r = 0; r < nrow; r++) begin
                    if (r < ((c < m) ? q + 1 : q)) begin
                        exp_b[pos] = sys_a[si]; exp_s[pos] = 0; si++;
                    end else begin
                        bit use1;
                        use1 = turn;
                        if (use1 && l1 == 0) begin use1 = 1'b0; rout = 1'b1; end
                        else if (!use1 && l2 == 0) begin use1 = 1'b1; rout = 1'b1; end
                        if (use1) begin exp_b[pos] = p1_a[ue1]; ue1++; l1--; end
                        else      begin exp_b[pos] = p2_a[ue2]; ue2++; l2--; end
                        exp_s[pos] = 1;
                        turn = ~turn;
                    end
                    pos++;
                end
            end
        end
        si = 0; i1 = 0; i2 = 0; n = 0; cyc = 0; stall_bad = 0;
        done_seen = 1'b0; err_seen = 1'b0; took_s = 1'b0; took_1 = 1'b0; took_2 = 1'b0;
        stalled = 1'b0;
        mode_i = 2'(mode); ndata_i = CW'(nd); ntsys_i = CW'(ns); np1_i = CW'(n1); np2_i = CW'(n2);
        sys_vld_i = 1'b1; p1_vld_i = 1'b1; p2_vld_i = 1'b1;
        sys_bit_i = sys_a[0]; p1_bit_i = p1_a[0]; p2_bit_i = p2_a[0];
        start_i = 1'b1;
        while (!done_seen && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (took_s) si++;
            if (took_1) i1++;
            if (took_2) i2++;
            if (stalled && out_vld_o) stall_bad++;
            if (out_vld_o) begin
                if (n < MAXB) got_b[n] = out_bit_o;
                n++;
            end
            if (done_o) begin done_seen = 1'b1; err_seen = err_o; end
            start_i = 1'b0;
            if (poke && cyc == 8) begin
                start_i = 1'b1; mode_i = 2'd2; ntsys_i = CW'(1); ndata_i = CW'(6);
            end else begin
                mode_i = 2'(mode); ntsys_i = CW'(ns); ndata_i = CW'(nd);
            end
            sys_vld_i = stall ? (cyc % 3 != 0) : 1'b1;
            p1_vld_i  = stall ? (cyc % 4 != 1) : 1'b1;
            p2_vld_i  = stall ? (cyc % 5 != 2) : 1'b1;
            sys_bit_i = sys_a[si % MAXB]; p1_bit_i = p1_a[i1 % MAXB]; p2_bit_i = p2_a[i2 % MAXB];
            #1;
            took_s = sys_rdy_o && sys_vld_i;
            took_1 = p1_rdy_o && p1_vld_i;
            took_2 = p2_rdy_o && p2_vld_i;
            stalled = (sys_rdy_o && !sys_vld_i) || (p1_rdy_o && !p1_vld_i) || (p2_rdy_o && !p2_vld_i);
        end
        start_i = 1'b0;
        check("R9", {name, " done seen"}, int'(done_seen), 1);
        if (cfg_err) begin
            check("R7", {name, " no bits on rejected start"}, n, 0);
            check("R7", {name, " err on rejected start"}, int'(err_seen), 1);
        end else begin
            check("R2", {name, " bit count"}, n, nd);
            for (int k = 0; k < nd && k < n && k < MAXB; k++) begin
                tag = (exp_s[k] == 0) ? "R3" : "R4";
                if (got_b[k] != exp_b[k]) begin
                    check(tag, $sformatf("%s bit %0d", name, k), int'(got_b[k]), int'(exp_b[k]));
                end
            end
            total++;
            check("R5", {name, " systematic consumed"}, si, ns);
            check("R5", {name, " parity1 consumed"}, i1, ue1);
            check("R5", {name, " parity2 consumed"}, i2, ue2);
            check("R8", {name, " err flag"}, int'(err_seen), int'(rout));
            if (stall) check("R6", {name, " output during stall"}, stall_bad, 0);
            if (poke) check("R10", {name, " start ignored while busy"}, n, nd);
        end
        @(negedge clk);
        check("R9", {name, " busy low after done"}, int'(busy_o), 0);
        check("R9", {name, " err held"}, int'(err_o), int'(cfg_err | rout));
    endtask

    task automatic t_modes();
        run_case("qpsk_partial", 0, 20, 7, 6, 7, 1'b0, 1'b0, 1'b0);
        run_case("qam16_even", 1, 24, 12, 6, 6, 1'b0, 1'b0, 1'b0);
        run_case("qam64_split", 2, 36, 20, 8, 8, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_edges();
        run_case("qpsk_nr0", 0, 8, 3, 2, 3, 1'b0, 1'b0, 1'b0);
        run_case("qam16_allpar", 1, 16, 0, 8, 8, 1'b0, 1'b0, 1'b0);
        run_case("qam64_allsys", 2, 12, 12, 0, 0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_stall();
        run_case("qam64_stall", 2, 240, 100, 70, 70, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_runout();
        run_case("qpsk_runout", 0, 12, 4, 5, 3, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_busy_start();
        run_case("qam16_poke", 1, 24, 9, 7, 8, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_reject();
        run_case("bad_mode", 3, 24, 12, 6, 6, 1'b0, 1'b0, 1'b1);
        run_case("odd_total", 0, 7, 3, 2, 2, 1'b0, 1'b0, 1'b1);
        run_case("zero_cols", 2, 4, 2, 1, 1, 1'b0, 1'b0, 1'b1);
        run_case("sys_over", 1, 16, 20, 0, 0, 1'b0, 1'b0, 1'b1);
        run_case("par_mismatch", 1, 16, 8, 4, 3, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R9 watchdog expired: actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_edges();
        t_stall();
        t_runout();
        t_busy_start();
        t_reject();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule